// File: doc/BRIEF.md
# UDP Sample Tap for a Wide Packet Stream

This block sits inline on a 256-bit AXI4-Stream packet path. Every frame passes straight from the input to the output with no register in between, so the block adds no latency to any traffic. While the beats go by, a small parser watches the accepted handshakes. It recognises an untagged Ethernet frame that carries IPv4 without options and UDP to a configured destination port. From such a frame it lifts a 32-bit sample value out of the UDP payload. In multi-stream mode it also lifts a 32-bit stream identifier that follows the value.

Each extracted sample goes into a one-entry output slot, together with a snapshot of three tuning values taken on the same cycle: model order, discount rate and window length. A downstream scoring engine drains the slot with a valid/ready handshake. The packet stream is never back-pressured. If the slot is still occupied and not being drained when a new sample arrives, the new sample is discarded and a drop counter advances. The block also keeps a register that holds the latest score returned by the downstream engine, so the host can read it.

Top module: `udp_sample_tap`

## Requirements
- R1: The outputs m_tdata, m_tkeep, m_tlast and m_tvalid equal s_tdata, s_tkeep, s_tlast and s_tvalid in the same cycle, and s_tready equals m_tready, for every frame whether or not it matches.
- R2: Frame byte n travels in beat n/32, lane n%32, at bits [8*(n%32)+7 : 8*(n%32)]. A frame is a candidate only if all of these hold: bytes 12 and 13 are 0x08 and 0x00, byte 14 is 0x45, byte 23 is 0x11, and bytes 36 and 37 (36 most significant) equal cfg_port. Any other frame produces no sample.
- R3: For a candidate, smp_value is bytes 42..45 with byte 42 most significant. smp_valid rises in the cycle after the clock edge that accepts beat 1, and a frame yields at most one sample.
- R4: With cfg_multi high, smp_sid is bytes 46..49 with byte 46 most significant. With cfg_multi low, smp_sid is zero.
- R5: A frame that ends on beat 0 yields no sample. So does a frame whose beat 1 has fewer than 14 valid lanes, or fewer than 18 in multi-stream mode. The bench assumes tkeep is contiguous from lane 0.
- R6: smp_order, smp_rate and smp_win are the values of cfg_order, cfg_rate and cfg_win on the edge that loads the slot. They stay unchanged while the slot holds that sample.
- R7: While smp_valid is high and smp_ready is low, smp_valid stays high and all slot outputs stay stable.
- R8: A sample that arrives while smp_valid is high and smp_ready is low is discarded, the held sample is kept, and drop_count rises by one (wrapping).
- R9: When score_in_valid is high at an edge, score_reg takes score_in. Otherwise score_reg keeps its value.
- R10: After reset, smp_valid, drop_count and score_reg are zero.
- R11: Only accepted beats (s_tvalid and m_tready both high) advance the parser. Beat 1 held under a stall produces its sample only after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 256 | Inbound beat data |
| s_tkeep | input | 32 | Inbound byte enables |
| s_tlast | input | 1 | Inbound end of frame |
| s_tvalid | input | 1 | Inbound beat valid |
| s_tready | output | 1 | Inbound ready (mirror of m_tready) |
| m_tdata | output | 256 | Outbound beat data |
| m_tkeep | output | 32 | Outbound byte enables |
| m_tlast | output | 1 | Outbound end of frame |
| m_tvalid | output | 1 | Outbound beat valid |
| m_tready | input | 1 | Outbound ready |
| cfg_port | input | 16 | UDP destination port to match |
| cfg_multi | input | 1 | Multi-stream payload format |
| cfg_order | input | 4 | Model order tuning value |
| cfg_rate | input | 32 | Discount rate tuning value |
| cfg_win | input | 4 | Smoothing window tuning value |
| smp_valid | output | 1 | Sample slot occupied |
| smp_ready | input | 1 | Downstream takes the sample |
| smp_value | output | 32 | Extracted sample value |
| smp_sid | output | 32 | Extracted stream identifier |
| smp_order | output | 4 | Order captured with the sample |
| smp_rate | output | 32 | Rate captured with the sample |
| smp_win | output | 4 | Window captured with the sample |
| drop_count | output | 16 | Samples discarded because the slot was full |
| score_in_valid | input | 1 | Returned score strobe |
| score_in | input | 32 | Returned score |
| score_reg | output | 32 | Latest returned score |

## Verification
On every cycle, the assertions check these properties: the slot holds steady under back-pressure, the drop counter moves only when a sample collides with a blocked slot, every parser hit shows up in an occupied slot on the next cycle, a frame never yields two samples in a row, and the score register follows its strobe. Other behaviours depend on the contents of particular frames, and only the bench's scenarios can show them. These are field matching against each header byte, byte ordering of value and identifier, the length cut-offs in both formats, the snapshot of tuning values, and the timing of a hit when beat 1 is stalled.

// File: rtl/ust_pkg.sv
// Package: shared frame-layout constants and widths for the UDP sample tap.
// Assumes untagged Ethernet followed by IPv4 without options.
package ust_pkg;
    localparam int SMP_W         = 32;
    localparam int SID_W         = 32;
    localparam int ETYPE_OFF     = 12;  // two bytes, network order
    localparam int VERIHL_OFF    = 14;  // version / header length byte
    localparam int PROTO_OFF     = 23;  // IP protocol byte
    localparam int DPORT_OFF     = 36;  // UDP destination port, two bytes
    localparam int VALUE_OFF     = 42;  // first payload byte
    localparam int SID_OFF       = 46;  // identifier after the value
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  VERIHL_V4  = 8'h45;
    localparam logic [7:0]  PROTO_UDP  = 8'h11;

    // Payload captured by the parser for one sample.
    typedef struct packed {
        logic [SMP_W-1:0] value;
        logic [SID_W-1:0] sid;
    } ust_sample_t;
endpackage

// File: rtl/ust_frame_parser.sv
// Module: ust_frame_parser
// Watches accepted beats and flags the one beat of a frame that completes
// a matching UDP sample. Header checks run on beat 0 and are kept in a
// register. The port, value and identifier are taken from beat 1.
// Assumes a 256-bit beat (all fields fall in beats 0 and 1) and a tkeep
// that is contiguous from lane 0.
module ust_frame_parser
    import ust_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int PORT_W = 16,
    localparam int BYTES  = DATA_W / 8,
    localparam int CNT_W  = $clog2(BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat_fire,
    input  logic [DATA_W-1:0]  tdata,
    input  logic [BYTES-1:0]   tkeep,
    input  logic               tlast,
    input  logic [PORT_W-1:0]  cfg_port,
    input  logic               cfg_multi,
    output logic               hit,
    output ust_sample_t        hit_smp
);
    localparam int ET_LANE  = ETYPE_OFF  % BYTES;
    localparam int VH_LANE  = VERIHL_OFF % BYTES;
    localparam int PR_LANE  = PROTO_OFF  % BYTES;
    localparam int DP_LANE  = DPORT_OFF  % BYTES;
    localparam int VAL_LANE = VALUE_OFF  % BYTES;
    localparam int SID_LANE = SID_OFF    % BYTES;
    localparam logic [CNT_W-1:0] NEED_ONE = CNT_W'(VAL_LANE + SMP_W / 8);
    localparam logic [CNT_W-1:0] NEED_TWO = CNT_W'(SID_LANE + SID_W / 8);

    typedef enum logic [1:0] {B_HDR = 2'd0, B_PAY = 2'd1, B_REST = 2'd2} beat_e;

    beat_e               beat_q;
    logic                hdr_ok_q;
    logic                hdr_ok;
    logic                port_ok;
    logic                len_ok;
    logic [CNT_W-1:0]    keep_cnt;
    logic [PORT_W-1:0]   port_field;

    // Position of the current beat in its frame, moved only by accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= B_HDR;
        end else if (beat_fire) begin
            if (tlast)                beat_q <= B_HDR;
            else if (beat_q == B_HDR) beat_q <= B_PAY;
            else                      beat_q <= B_REST;
        end
    end

    // Header checks on beat 0: EtherType, plain IPv4 header, UDP protocol.
    always_comb begin
        hdr_ok = ({tdata[8*ET_LANE +: 8], tdata[8*(ET_LANE+1) +: 8]} == ETYPE_IPV4)
              && (tdata[8*VH_LANE +: 8] == VERIHL_V4)
              && (tdata[8*PR_LANE +: 8] == PROTO_UDP);
    end

    // Hold the beat-0 verdict for use on beat 1; a one-beat frame never qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok_q <= 1'b0;
        end else if (beat_fire && beat_q == B_HDR) begin
            hdr_ok_q <= hdr_ok && !tlast;
        end
    end

    // Count valid lanes of the current beat.
    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < BYTES; i++) begin
            keep_cnt = keep_cnt + CNT_W'(tkeep[i]);
        end
    end

    // Beat-1 checks: destination port and enough payload for the chosen format.
    always_comb begin
        port_field = PORT_W'({tdata[8*DP_LANE +: 8], tdata[8*(DP_LANE+1) +: 8]});
        port_ok    = (port_field == cfg_port);
        len_ok     = cfg_multi ? (keep_cnt >= NEED_TWO) : (keep_cnt >= NEED_ONE);
        hit        = beat_fire && (beat_q == B_PAY) && hdr_ok_q && port_ok && len_ok;
    end

    // Assemble the value and identifier in network byte order.
    always_comb begin
        for (int i = 0; i < SMP_W / 8; i++) begin
            hit_smp.value[SMP_W-1-8*i -: 8] = tdata[8*(VAL_LANE+i) +: 8];
        end
        for (int i = 0; i < SID_W / 8; i++) begin
            hit_smp.sid[SID_W-1-8*i -: 8] = cfg_multi ? tdata[8*(SID_LANE+i) +: 8] : 8'h00;
        end
    end

    // R3, R5: one frame yields at most one sample; no two hits back to back.
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/ust_sample_slot.sv
// Module: ust_sample_slot
// One-entry holding register between the parser and the scoring engine.
// It captures the sample with a snapshot of the tuning values. It discards
// a new sample if the slot is full and not being drained, and counts that.
// Assumes the downstream side takes a sample whenever valid and ready meet.
module ust_sample_slot
    import ust_pkg::*;
#(
    parameter int ORDER_W = 4,
    parameter int RATE_W  = 32,
    parameter int WIN_W   = 4,
    parameter int DROP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  ust_sample_t        hit_smp,
    input  logic [ORDER_W-1:0] cfg_order,
    input  logic [RATE_W-1:0]  cfg_rate,
    input  logic [WIN_W-1:0]   cfg_win,
    input  logic               smp_ready,
    output logic               smp_valid,
    output logic [SMP_W-1:0]   smp_value,
    output logic [SID_W-1:0]   smp_sid,
    output logic [ORDER_W-1:0] smp_order,
    output logic [RATE_W-1:0]  smp_rate,
    output logic [WIN_W-1:0]   smp_win,
    output logic [DROP_W-1:0]  drop_count
);
    logic can_load;
    logic blocked;

    // Slot accepts a sample when empty or being drained this cycle.
    always_comb begin
        can_load = !smp_valid || smp_ready;
        blocked  = smp_valid && !smp_ready;
    end

    // Occupancy flag of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        smp_valid <= 1'b0;
        else if (can_load) smp_valid <= hit;
    end

    // Sample and tuning snapshot, loaded only on an accepted hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_value <= '0;
            smp_sid   <= '0;
            smp_order <= '0;
            smp_rate  <= '0;
            smp_win   <= '0;
        end else if (can_load && hit) begin
            smp_value <= hit_smp.value;
            smp_sid   <= hit_smp.sid;
            smp_order <= cfg_order;
            smp_rate  <= cfg_rate;
            smp_win   <= cfg_win;
        end
    end

    // Count samples lost to a full slot.
    always_ff @(posedge clk) begin
        if (!rst_n)              drop_count <= '0;
        else if (blocked && hit) drop_count <= drop_count + 1'b1;
    end

    // R7: a blocked slot keeps its sample and its tuning snapshot.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_value)
            && $stable(smp_sid) && $stable(smp_order) && $stable(smp_rate) && $stable(smp_win)));

    // R8: the drop counter moves only after a hit collided with a blocked slot.
    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(smp_valid && !smp_ready && hit));

    // R3: the slot becomes occupied only after a parser hit.
    p_rise_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> $past(hit));
endmodule

// File: rtl/ust_score_hold.sv
// Module: ust_score_hold
// Keeps the latest score returned by the scoring engine for host reads.
// Assumes one strobe per returned score.
module ust_score_hold #(
    parameter int SCORE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               score_in_valid,
    input  logic [SCORE_W-1:0] score_in,
    output logic [SCORE_W-1:0] score_reg
);
    // Load the returned score on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              score_reg <= '0;
        else if (score_in_valid) score_reg <= score_in;
    end

    // R9: a strobe lands the score in the register on the next cycle.
    p_score_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        score_in_valid |=> (score_reg == $past(score_in)));
endmodule

// File: rtl/udp_sample_tap.sv
// Module: udp_sample_tap (top)
// Zero-latency pass-through of a wide AXI4-Stream packet path. A parser on
// the side taps UDP samples into a one-entry slot for a scoring engine, and
// a register holds the latest returned score.
// Assumes the downstream packet sink never depends on the tap's state.
module udp_sample_tap #(
    parameter int DATA_W  = 256,
    parameter int PORT_W  = 16,
    parameter int ORDER_W = 4,
    parameter int RATE_W  = 32,
    parameter int WIN_W   = 4,
    parameter int DROP_W  = 16,
    parameter int SCORE_W = 32,
    localparam int KEEP_W = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  s_tdata,
    input  logic [KEEP_W-1:0]  s_tkeep,
    input  logic               s_tlast,
    input  logic               s_tvalid,
    output logic               s_tready,
    output logic [DATA_W-1:0]  m_tdata,
    output logic [KEEP_W-1:0]  m_tkeep,
    output logic               m_tlast,
    output logic               m_tvalid,
    input  logic               m_tready,
    input  logic [PORT_W-1:0]  cfg_port,
    input  logic               cfg_multi,
    input  logic [ORDER_W-1:0] cfg_order,
    input  logic [RATE_W-1:0]  cfg_rate,
    input  logic [WIN_W-1:0]   cfg_win,
    output logic               smp_valid,
    input  logic               smp_ready,
    output logic [31:0]        smp_value,
    output logic [31:0]        smp_sid,
    output logic [ORDER_W-1:0] smp_order,
    output logic [RATE_W-1:0]  smp_rate,
    output logic [WIN_W-1:0]   smp_win,
    output logic [DROP_W-1:0]  drop_count,
    input  logic               score_in_valid,
    input  logic [SCORE_W-1:0] score_in,
    output logic [SCORE_W-1:0] score_reg
);
    import ust_pkg::*;

    logic        beat_fire;
    logic        hit;
    ust_sample_t hit_smp;

    // Straight wiring of the packet path; no register on the way.
    always_comb begin
        m_tdata   = s_tdata;
        m_tkeep   = s_tkeep;
        m_tlast   = s_tlast;
        m_tvalid  = s_tvalid;
        s_tready  = m_tready;
        beat_fire = s_tvalid && m_tready;
    end

    ust_frame_parser #(
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_fire (beat_fire),
        .tdata     (s_tdata),
        .tkeep     (s_tkeep),
        .tlast     (s_tlast),
        .cfg_port  (cfg_port),
        .cfg_multi (cfg_multi),
        .hit       (hit),
        .hit_smp   (hit_smp)
    );

    ust_sample_slot #(
        .ORDER_W (ORDER_W),
        .RATE_W  (RATE_W),
        .WIN_W   (WIN_W),
        .DROP_W  (DROP_W)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .hit_smp    (hit_smp),
        .cfg_order  (cfg_order),
        .cfg_rate   (cfg_rate),
        .cfg_win    (cfg_win),
        .smp_ready  (smp_ready),
        .smp_valid  (smp_valid),
        .smp_value  (smp_value),
        .smp_sid    (smp_sid),
        .smp_order  (smp_order),
        .smp_rate   (smp_rate),
        .smp_win    (smp_win),
        .drop_count (drop_count)
    );

    ust_score_hold #(
        .SCORE_W (SCORE_W)
    ) u_score (
        .clk            (clk),
        .rst_n          (rst_n),
        .score_in_valid (score_in_valid),
        .score_in       (score_in),
        .score_reg      (score_reg)
    );

    // R3: every parser hit leaves the slot occupied on the next cycle.
    p_emit_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> smp_valid);

    // R11: the parser never fires on a beat that was not accepted.
    p_hit_needs_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && !m_tready) |-> !hit);
endmodule

// File: tb/udp_sample_tap_bench.sv
// Directed bench for udp_sample_tap: one task per scenario.
module udp_sample_tap_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PORT = 16'h1388;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] s_tdata = '0;
    logic [31:0]  s_tkeep = '0;
    logic         s_tlast = 1'b0;
    logic         s_tvalid = 1'b0;
    logic         s_tready;
    logic [255:0] m_tdata;
    logic [31:0]  m_tkeep;
    logic         m_tlast;
    logic         m_tvalid;
    logic         m_tready = 1'b1;
    logic [15:0]  cfg_port = PORT;
    logic         cfg_multi = 1'b0;
    logic [3:0]   cfg_order = 4'd2;
    logic [31:0]  cfg_rate = 32'h3A83126F;
    logic [3:0]   cfg_win = 4'd8;
    logic         smp_valid;
    logic         smp_ready = 1'b1;
    logic [31:0]  smp_value;
    logic [31:0]  smp_sid;
    logic [3:0]   smp_order;
    logic [31:0]  smp_rate;
    logic [3:0]   smp_win;
    logic [15:0]  drop_count;
    logic         score_in_valid = 1'b0;
    logic [31:0]  score_in = '0;
    logic [31:0]  score_reg;

    int checks = 0;
    int bad = 0;

    logic [7:0] fr [0:127];
    int         got;
    logic [31:0] got_val;
    logic [31:0] got_sid;
    int         got_early;
    bit         pass_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    udp_sample_tap u_udp_sample_tap (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Note a sample taken by the engine (ready held high by the caller).
    task automatic observe();
        if (smp_valid && smp_ready) begin
            got++;
            got_val = smp_value;
            got_sid = smp_sid;
        end
    endtask

    // Fill a well-formed matching frame; scenarios patch bytes afterwards.
    task automatic build(input logic [31:0] val, input logic [31:0] sid);
        for (int i = 0; i < 128; i++) fr[i] = 8'(i * 7 + 3);
        fr[12] = 8'h08; fr[13] = 8'h00; fr[14] = 8'h45; fr[23] = 8'h11;
        fr[36] = PORT[15:8]; fr[37] = PORT[7:0];
        fr[42] = val[31:24]; fr[43] = val[23:16]; fr[44] = val[15:8]; fr[45] = val[7:0];
        fr[46] = sid[31:24]; fr[47] = sid[23:16]; fr[48] = sid[15:8]; fr[49] = sid[7:0];
    endtask

    // Send fr[0..len-1]; optionally stall beat 1 for a few cycles.
    task automatic send(input int len, input int stall);
        int nb;
        nb = (len + 31) / 32;
        got = 0; got_early = 0; pass_bad = 0;
        for (int b = 0; b < nb; b++) begin
            for (int l = 0; l < 32; l++) begin
                s_tdata[8*l +: 8] = (b*32 + l < len) ? fr[b*32 + l] : 8'h00;
                s_tkeep[l]        = (b*32 + l < len);
            end
            s_tlast  = (b == nb - 1);
            s_tvalid = 1'b1;
            if (b == 1 && stall > 0) begin
                m_tready = 1'b0;
                for (int s = 0; s < stall; s++) begin
                    #1;
                    if (s_tready !== 1'b0) pass_bad = 1;
                    tick();
                    observe();
                end
                got_early = got;
                m_tready = 1'b1;
            end
            #1;
            if (m_tdata !== s_tdata || m_tkeep !== s_tkeep || m_tlast !== s_tlast
                || m_tvalid !== 1'b1 || s_tready !== m_tready) pass_bad = 1;
            tick();
            observe();
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        tick();
        observe();
    endtask

    task automatic t_reset();
        chk(smp_valid == 1'b0, "R10 smp_valid", 64'(smp_valid), 0);
        chk(drop_count == 0, "R10 drop_count", 64'(drop_count), 0);
        chk(score_reg == 0, "R10 score_reg", 64'(score_reg), 0);
    endtask

    task automatic t_single();
        build(32'h40490FDB, 32'hDEADBEEF);
        send(64, 0);
        chk(got == 1, "R3 one sample", 64'(got), 1);
        chk(got_val == 32'h40490FDB, "R3 value order", 64'(got_val), 64'h40490FDB);
        chk(got_sid == 0, "R4 sid zero single mode", 64'(got_sid), 0);
        chk(pass_bad == 0, "R1 pass-through", 64'(pass_bad), 0);
        build(32'h3F800000, 0);
        send(100, 0);
        chk(got == 1 && got_val == 32'h3F800000, "R3 four-beat frame", 64'(got_val), 64'h3F800000);
        chk(pass_bad == 0, "R1 pass-through long frame", 64'(pass_bad), 0);
    endtask

    task automatic t_reject();
        build(32'h11111111, 0); fr[37] = 8'h89; send(64, 0);
        chk(got == 0, "R2 wrong port", 64'(got), 0);
        chk(pass_bad == 0, "R1 pass-through non-matching", 64'(pass_bad), 0);
        build(32'h11111111, 0); fr[12] = 8'h08; fr[13] = 8'h06; send(64, 0);
        chk(got == 0, "R2 wrong ethertype", 64'(got), 0);
        build(32'h11111111, 0); fr[23] = 8'h01; send(64, 0);
        chk(got == 0, "R2 wrong protocol", 64'(got), 0);
        build(32'h11111111, 0); fr[14] = 8'h46; send(64, 0);
        chk(got == 0, "R2 ip options present", 64'(got), 0);
    endtask

    task automatic t_multi();
        cfg_multi = 1'b1;
        build(32'hC0000000, 32'h00012345);
        send(64, 0);
        chk(got == 1 && got_sid == 32'h00012345, "R4 sid order", 64'(got_sid), 64'h00012345);
        chk(got_val == 32'hC0000000, "R4 value in multi mode", 64'(got_val), 64'hC0000000);
        send(49, 0);
        chk(got == 0, "R5 multi frame 49 bytes", 64'(got), 0);
        send(50, 0);
        chk(got == 1, "R5 multi frame 50 bytes", 64'(got), 1);
        cfg_multi = 1'b0;
    endtask

    task automatic t_length();
        build(32'h22222222, 0);
        send(32, 0);
        chk(got == 0, "R5 one-beat frame", 64'(got), 0);
        send(45, 0);
        chk(got == 0, "R5 frame 45 bytes", 64'(got), 0);
        send(46, 0);
        chk(got == 1 && got_val == 32'h22222222, "R5 frame 46 bytes", 64'(got_val), 64'h22222222);
    endtask

    task automatic t_stall();
        build(32'h55667788, 0);
        send(64, 3);
        chk(got_early == 0, "R11 no sample during stall", 64'(got_early), 0);
        chk(got == 1 && got_val == 32'h55667788, "R11 sample after accept", 64'(got_val), 64'h55667788);
        chk(pass_bad == 0, "R1 ready mirrored in stall", 64'(pass_bad), 0);
    endtask

    task automatic t_drop();
        smp_ready = 1'b0;
        cfg_order = 4'd3; cfg_rate = 32'h3B03126F; cfg_win = 4'd5;
        build(32'hAAAA0001, 0);
        send(64, 0);
        chk(smp_valid == 1'b1 && smp_value == 32'hAAAA0001, "R7 held sample", 64'(smp_value), 64'hAAAA0001);
        chk(smp_order == 3 && smp_rate == 32'h3B03126F && smp_win == 5, "R6 snapshot",
            {28'h0, smp_order, smp_rate}, {28'h0, 4'd3, 32'h3B03126F});
        cfg_order = 4'd7; cfg_rate = 32'h0; cfg_win = 4'd1;
        build(32'hBBBB0002, 0);
        send(64, 0);
        chk(drop_count == 1, "R8 drop counted", 64'(drop_count), 1);
        chk(smp_value == 32'hAAAA0001, "R8 old sample kept", 64'(smp_value), 64'hAAAA0001);
        chk(smp_order == 3 && smp_win == 5, "R6 snapshot unchanged", 64'(smp_order), 3);
        smp_ready = 1'b1;
        tick();
        chk(smp_valid == 1'b0, "R7 slot drained", 64'(smp_valid), 0);
        cfg_order = 4'd2; cfg_rate = 32'h3A83126F; cfg_win = 4'd8;
    endtask

    task automatic t_score();
        score_in = 32'h41200000; score_in_valid = 1'b1;
        tick();
        score_in_valid = 1'b0;
        chk(score_reg == 32'h41200000, "R9 score loaded", 64'(score_reg), 64'h41200000);
        score_in = 32'h12345678;
        tick();
        chk(score_reg == 32'h41200000, "R9 score held", 64'(score_reg), 64'h41200000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_reject();
        t_multi();
        t_length();
        t_stall();
        t_drop();
        t_score();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule